// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor Core

This block collects a parameterised number of interrupt input lines (64 by default) and hands them out to one or two processors. For every line it keeps the last seen input level, an enable bit, a pending bit, an active bit, a routing mask and a trigger configuration. Lines configured as edge-triggered latch a pending state on any rising input, even while disabled. Lines configured as level-sensitive only pend while enabled, and they come back when they are completed while their input is still high.

Software reaches the state through a byte-wide register port. That port covers enable set and clear, per-line priority, routing, and trigger configuration. The lowest 32 lines keep a separate priority for each CPU. Every line above that keeps one priority shared by both CPUs.

Each CPU has an acknowledge port. It returns the best pending line on the next cycle, moves that line from pending to active, and returns the code 1023 when nothing is waiting. Each CPU also has a completion port that ends the active state. A per-CPU request output is high while an enabled pending line is routed to that CPU.

Top module: `irq_distributor`

## Requirements
- R1: After reset, lines 0..15 are enabled and edge-triggered, and all other lines are disabled and level-sensitive. All priorities are 0, every line routes to CPU0 only, nothing is pending or active, both acknowledge results read 1023, and `irq_out` is 0.
- R2: A rising input on an edge-triggered line that routes to at least one CPU sets pending whether or not the line is enabled. A pending line that is disabled does not drive `irq_out` and is not acknowledged until it is enabled.
- R3: A rising input on a level-sensitive line sets pending only if the line is enabled. Enabling a level-sensitive line whose recorded input is high sets pending in the same write.
- R4: An acknowledge request on CPU c updates that CPU's 10-bit result on the next cycle. Among enabled pending lines routed to c, the result is the one with the numerically lowest priority value, and ties go to the lowest line number. That line's pending bit is cleared and its active bit is set. If no line qualifies, the result is 1023.
- R5: A completion from CPU c naming an active line clears its active bit. If the line is level-sensitive, still enabled, its recorded input is still high and it routes to c, the line becomes pending again. Edge-triggered lines never re-pend on completion.
- R6: `irq_out[c]` is high exactly while some enabled pending line routes to CPU c.
- R7: The priority byte of line n is at address 0x400+n. For n < 32 the value is banked: `reg_cpu` selects which CPU's copy is written and read. For n >= 32 a single value serves both CPUs.
- R8: The configuration byte at 0xC00+k covers lines 4k..4k+3. Line 4k+i uses bit 2i+1 as edge-trigger select (1 = edge) and bit 2i as a model bit that is only stored and read back.
- R9: Writing 0x100+k sets the enable of line 8k+i for every 1 in data bit i. Writing 0x180+k clears those enables. Zero bits leave enables untouched, and a read of either address returns the eight enable bits.
- R10: The routing byte of line n is at 0x800+n, with bit c selecting CPU c. With a single CPU configured, every line routes to CPU0 and the byte reads 1.
- R11: An access whose address falls outside the five windows, or whose line number is at or above `NUM_IRQ`, raises `reg_bad` in the same cycle. Such an access returns 0 on `reg_rdata` and changes no state.
- R12: When both CPUs request acknowledge in the same cycle, CPU0 selects first. CPU1 then selects from its candidates with CPU0's choice removed, so one line is never granted twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Interrupt input lines |
| reg_sel | input | 1 | Register access valid |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_cpu | input | 1 | CPU whose banked priority is accessed |
| reg_rdata | output | 8 | Read data (combinational) |
| reg_bad | output | 1 | Access rejected |
| ack_req | input | NUM_CPU | Acknowledge request per CPU |
| ack_id | output | NUM_CPU*10 | Acknowledged line per CPU, 1023 = none |
| cmpl_req | input | NUM_CPU | Completion request per CPU |
| cmpl_id | input | NUM_CPU*10 | Line being completed per CPU |
| irq_out | output | NUM_CPU | Interrupt request per CPU |

## Verification
Two acknowledge selections can fall in the same cycle when both CPUs request at once. The bench provokes this by pulsing two edge lines routed to both CPUs, and then one such line alone, with both requests raised on the same edge. It judges the results by the distinct line numbers, or by 1023 on CPU1 when only one line was waiting. Completion of a still-high level line can also meet the re-pend condition. The bench checks this from the routed CPU and from the other CPU, and verifies that re-pend happens only in the first case.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

    typedef enum logic [2:0] {
        RG_NONE, RG_EN_SET, RG_EN_CLR, RG_PRIO, RG_TGT, RG_CFG
    } reg_kind_e;

    typedef struct packed {
        logic edge_trig;
        logic model;
    } irq_cfg_t;

    function automatic reg_kind_e addr_kind(input logic [11:0] a);
        if (a[11:7] == 5'b00010) return RG_EN_SET;
        if (a[11:7] == 5'b00011) return RG_EN_CLR;
        if (a[11:10] == 2'b01)   return RG_PRIO;
        if (a[11:10] == 2'b10)   return RG_TGT;
        if (a[11:8] == 4'b1100)  return RG_CFG;
        return RG_NONE;
    endfunction

    // first line number covered by an address
    function automatic int addr_base(input logic [11:0] a, input reg_kind_e k);
        case (k)
            RG_EN_SET, RG_EN_CLR: return int'({a[6:0], 3'b000});
            RG_PRIO, RG_TGT:      return int'(a[9:0]);
            RG_CFG:               return int'({a[7:0], 2'b00});
            default:              return 0;
        endcase
    endfunction
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ    = 64,
    parameter int NUM_CPU    = 2,
    parameter int BANKED     = 32,
    parameter int PRIO_W     = 8,
    parameter int RESET_EDGE = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [11:0]        reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic               reg_cpu,
    output logic [7:0]         reg_rdata,
    output logic               reg_bad,
    output logic [NUM_IRQ-1:0] en_o,
    output logic [NUM_IRQ-1:0] edge_o,
    output logic [NUM_IRQ-1:0] en_rise_o,
    output logic [NUM_CPU-1:0] tgt_o  [NUM_IRQ],
    output logic [PRIO_W-1:0]  prio_o [NUM_CPU][NUM_IRQ]
);
    reg_kind_e kind;
    int        base;
    int        cpu_i;
    logic      ok, we;
    logic [NUM_IRQ-1:0] model_v;

    assign kind    = addr_kind(reg_addr);
    assign base    = addr_base(reg_addr, kind);
    assign cpu_i   = (NUM_CPU > 1) ? int'(reg_cpu) : 0;
    assign ok      = (kind != RG_NONE) && (base < NUM_IRQ);
    assign we      = reg_sel && reg_wr && ok;
    assign reg_bad = reg_sel && !ok;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        logic set_h, clr_h, cfg_h, tgt_h, prio_h;
        logic en_q;
        irq_cfg_t cfg_q;
        logic [NUM_CPU-1:0] tgt_q;

        assign set_h  = we && (kind == RG_EN_SET) && (base == (i / 8) * 8) && reg_wdata[i % 8];
        assign clr_h  = we && (kind == RG_EN_CLR) && (base == (i / 8) * 8) && reg_wdata[i % 8];
        assign cfg_h  = we && (kind == RG_CFG)    && (base == (i / 4) * 4);
        assign tgt_h  = we && (kind == RG_TGT)    && (base == i);
        assign prio_h = we && (kind == RG_PRIO)   && (base == i);

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q  <= (i < RESET_EDGE);
                cfg_q <= '{edge_trig: (i < RESET_EDGE), model: 1'b0};
                tgt_q <= NUM_CPU'(1);
            end else begin
                if (set_h)      en_q <= 1'b1;
                else if (clr_h) en_q <= 1'b0;
                if (cfg_h)
                    cfg_q <= '{edge_trig: reg_wdata[2 * (i % 4) + 1],
                               model:     reg_wdata[2 * (i % 4)]};
                if (tgt_h) tgt_q <= reg_wdata[NUM_CPU-1:0];
            end
        end

        assign en_o[i]      = en_q;
        assign edge_o[i]    = cfg_q.edge_trig;
        assign model_v[i]   = cfg_q.model;
        assign en_rise_o[i] = set_h && !en_q;
        assign tgt_o[i]     = (NUM_CPU == 1) ? '1 : tgt_q;

        if (i < BANKED) begin : g_bank
            for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
                logic [PRIO_W-1:0] p_q;
                always_ff @(posedge clk) begin
                    if (rst)                          p_q <= '0;
                    else if (prio_h && (cpu_i == c))  p_q <= reg_wdata[PRIO_W-1:0];
                end
                assign prio_o[c][i] = p_q;
            end
        end else begin : g_shared
            logic [PRIO_W-1:0] p_q;
            always_ff @(posedge clk) begin
                if (rst)         p_q <= '0;
                else if (prio_h) p_q <= reg_wdata[PRIO_W-1:0];
            end
            for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
                assign prio_o[c][i] = p_q;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel && ok) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                case (kind)
                    RG_EN_SET, RG_EN_CLR:
                        if (base == (i / 8) * 8) reg_rdata[3'(i % 8)] = en_o[i];
                    RG_PRIO:
                        if (base == i)
                            for (int c = 0; c < NUM_CPU; c++)
                                if (c == cpu_i) reg_rdata[PRIO_W-1:0] = prio_o[c][i];
                    RG_TGT:
                        if (base == i) reg_rdata[NUM_CPU-1:0] = tgt_o[i];
                    RG_CFG:
                        if (base == (i / 4) * 4) begin
                            reg_rdata[3'(2 * (i % 4) + 1)] = edge_o[i];
                            reg_rdata[3'(2 * (i % 4))]     = model_v[i];
                        end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8,
    localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] cand,
    input  logic [PRIO_W-1:0]  prio [NUM_IRQ],
    output logic               found,
    output logic [IRQ_W-1:0]   id
);
    logic [PRIO_W-1:0] best;

    // scan downward so equal priorities end on the lowest number
    always_comb begin
        found = 1'b0;
        id    = '0;
        best  = '1;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (cand[i] && (!found || prio[i] <= best)) begin
                found = 1'b1;
                id    = IRQ_W'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/irqd_track.sv
module irqd_track
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_IRQ-1:0]      irq_in,
    input  logic [NUM_IRQ-1:0]      en,
    input  logic [NUM_IRQ-1:0]      edge_m,
    input  logic [NUM_IRQ-1:0]      en_rise,
    input  logic [NUM_CPU-1:0]      tgt [NUM_IRQ],
    input  logic [NUM_IRQ-1:0]      ack_take,
    input  logic [NUM_CPU-1:0]      cmpl_req,
    input  logic [NUM_CPU*ID_W-1:0] cmpl_id,
    output logic [NUM_IRQ-1:0]      pend
);
    logic [NUM_IRQ-1:0] lvl_q, act_q, tgt_any, rise, done_m, repend;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_any
        assign tgt_any[i] = |tgt[i];
    end

    assign rise = irq_in & ~lvl_q;

    always_comb begin
        done_m = '0;
        repend = '0;
        for (int c = 0; c < NUM_CPU; c++)
            for (int i = 0; i < NUM_IRQ; i++)
                if (cmpl_req[c] && cmpl_id[c*ID_W +: ID_W] == ID_W'(i) && act_q[i]) begin
                    done_m[i] = 1'b1;
                    if (!edge_m[i] && en[i] && lvl_q[i] && tgt[i][c]) repend[i] = 1'b1;
                end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            pend  <= '0;
            act_q <= '0;
        end else begin
            lvl_q <= irq_in;
            pend  <= (pend & ~ack_take)
                   | (rise & (edge_m | en) & tgt_any)
                   | (en_rise & ~edge_m & lvl_q & tgt_any)
                   | repend;
            act_q <= (act_q & ~done_m) | ack_take;
        end
    end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ    = 64,
    parameter int NUM_CPU    = 2,
    parameter int BANKED     = 32,
    parameter int PRIO_W     = 8,
    parameter int RESET_EDGE = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_IRQ-1:0]      irq_in,
    input  logic                    reg_sel,
    input  logic                    reg_wr,
    input  logic [11:0]             reg_addr,
    input  logic [7:0]              reg_wdata,
    input  logic                    reg_cpu,
    output logic [7:0]              reg_rdata,
    output logic                    reg_bad,
    input  logic [NUM_CPU-1:0]      ack_req,
    output logic [NUM_CPU*ID_W-1:0] ack_id,
    input  logic [NUM_CPU-1:0]      cmpl_req,
    input  logic [NUM_CPU*ID_W-1:0] cmpl_id,
    output logic [NUM_CPU-1:0]      irq_out
);
    localparam int IRQ_W = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0] en, edge_m, en_rise, pend;
    logic [NUM_CPU-1:0] tgt  [NUM_IRQ];
    logic [PRIO_W-1:0]  prio [NUM_CPU][NUM_IRQ];
    logic [NUM_IRQ-1:0] taken [NUM_CPU+1];

    irqd_regs #(
        .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .BANKED(BANKED),
        .PRIO_W(PRIO_W), .RESET_EDGE(RESET_EDGE)
    ) regs_i (
        .clk, .rst, .reg_sel, .reg_wr, .reg_addr, .reg_wdata, .reg_cpu,
        .reg_rdata, .reg_bad,
        .en_o(en), .edge_o(edge_m), .en_rise_o(en_rise), .tgt_o(tgt), .prio_o(prio)
    );

    irqd_track #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) track_i (
        .clk, .rst, .irq_in, .en, .edge_m, .en_rise, .tgt,
        .ack_take(taken[NUM_CPU]), .cmpl_req, .cmpl_id, .pend
    );

    assign taken[0] = '0;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_IRQ-1:0] routed, cand;
        logic               found;
        logic [IRQ_W-1:0]   pick;
        logic [ID_W-1:0]    id_q;

        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_col
            assign routed[i] = tgt[i][c];
        end

        assign cand       = pend & en & routed & ~taken[c];
        assign irq_out[c] = |(pend & en & routed);

        irqd_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) pick_i (
            .cand, .prio(prio[c]), .found, .id(pick)
        );

        assign taken[c+1] = taken[c]
                          | ((ack_req[c] && found) ? (NUM_IRQ'(1) << pick) : '0);

        always_ff @(posedge clk) begin
            if (rst)             id_q <= ID_NONE;
            else if (ack_req[c]) id_q <= found ? ID_W'(pick) : ID_NONE;
        end
        assign ack_id[c*ID_W +: ID_W] = id_q;
    end
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_sel,
    input logic [11:0]           reg_addr,
    input logic                  reg_bad,
    input logic [NUM_CPU-1:0]    ack_req,
    input logic [NUM_CPU*10-1:0] ack_id,
    input logic [NUM_CPU-1:0]    irq_out
);
    // R4
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_req[0] && !irq_out[0]) |=> ack_id[9:0] == 10'd1023);

    // R6
    ack_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_req[0] && irq_out[0]) |=> ack_id[9:0] < NUM_IRQ);

    // R11
    bad_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_addr[11:10] == 2'b01 && reg_addr[9:0] >= NUM_IRQ) |-> reg_bad);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_rng
        // R4
        id_range_chk: assert property (@(posedge clk) disable iff (rst)
            (ack_id[c*10 +: 10] < NUM_IRQ) || (ack_id[c*10 +: 10] == 10'd1023));
    end

    if (NUM_CPU > 1) begin : g_dual
        // R12
        dual_ack_chk: assert property (@(posedge clk) disable iff (rst)
            (ack_req[0] && ack_req[1]) |=>
            (ack_id[9:0] != ack_id[19:10]) || (ack_id[9:0] == 10'd1023));
    end
endmodule

bind irq_distributor irq_distributor_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) chk_i (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_addr(reg_addr), .reg_bad(reg_bad),
    .ack_req(ack_req), .ack_id(ack_id), .irq_out(irq_out)
);

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb_top;
    localparam int NI = 64;
    localparam int NC = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NI-1:0]   irq_in = '0;
    logic            reg_sel = 1'b0, reg_wr = 1'b0, reg_cpu = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic            reg_bad;
    logic [NC-1:0]   ack_req = '0, cmpl_req = '0;
    logic [NC*10-1:0] ack_id;
    logic [NC*10-1:0] cmpl_id = '0;
    logic [NC-1:0]   irq_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_distributor #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut_i (
        .clk, .rst, .irq_in, .reg_sel, .reg_wr, .reg_addr, .reg_wdata, .reg_cpu,
        .reg_rdata, .reg_bad, .ack_req, .ack_id, .cmpl_req, .cmpl_id, .irq_out
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [7:0]  wd;
        logic        cpu;
        logic [7:0]  exp;
        logic        bad;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h405, 8'h40, 1'b0, 8'h40, 1'b0},  // R7 banked write cpu0
        '{1'b0, 12'h405, 8'h00, 1'b1, 8'h00, 1'b0},  // R7 cpu1 copy untouched
        '{1'b1, 12'h428, 8'h33, 1'b1, 8'h33, 1'b0},  // R7 shared write via cpu1
        '{1'b0, 12'h428, 8'h00, 1'b0, 8'h33, 1'b0},  // R7 shared read via cpu0
        '{1'b1, 12'h440, 8'h11, 1'b0, 8'h00, 1'b1},  // R11 line 64 priority
        '{1'b1, 12'h108, 8'hFF, 1'b0, 8'h00, 1'b1},  // R11 enable byte past end
        '{1'b1, 12'h188, 8'hFF, 1'b0, 8'h00, 1'b1},  // R11 clear byte past end
        '{1'b0, 12'h100, 8'h00, 1'b0, 8'hFF, 1'b0},  // R11 enables 0..7 unchanged
        '{1'b1, 12'h300, 8'h12, 1'b0, 8'h00, 1'b1},  // R11 unmapped
        '{1'b1, 12'hC05, 8'h5A, 1'b0, 8'h5A, 1'b0},  // R8 config 20..23
        '{1'b1, 12'h106, 8'h81, 1'b0, 8'h81, 1'b0},  // R9 set 48,55
        '{1'b1, 12'h186, 8'h01, 1'b0, 8'h80, 1'b0},  // R9 clear 48
        '{1'b1, 12'h106, 8'h00, 1'b0, 8'h80, 1'b0},  // R9 zeros no effect
        '{1'b1, 12'h186, 8'h80, 1'b0, 8'h00, 1'b0},  // R9 clear 55
        '{1'b1, 12'h830, 8'h03, 1'b0, 8'h03, 1'b0},  // R10 route 48 to both
        '{1'b1, 12'h830, 8'h01, 1'b0, 8'h01, 1'b0}   // R10 restore
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic c);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_cpu = c;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic c, output logic [7:0] d, output logic b);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_cpu = c;
        #1;
        d = reg_rdata; b = reg_bad;
        reg_sel = 1'b0;
    endtask

    task automatic ack(input int c, output logic [9:0] id);
        @(negedge clk);
        ack_req[c] = 1'b1;
        @(negedge clk);
        ack_req[c] = 1'b0;
        id = ack_id[c*10 +: 10];
    endtask

    task automatic ack2(output logic [9:0] id0, output logic [9:0] id1);
        @(negedge clk);
        ack_req = 2'b11;
        @(negedge clk);
        ack_req = 2'b00;
        id0 = ack_id[9:0];
        id1 = ack_id[19:10];
    endtask

    task automatic cmpl(input int c, input logic [9:0] id);
        @(negedge clk);
        cmpl_req[c] = 1'b1; cmpl_id[c*10 +: 10] = id;
        @(negedge clk);
        cmpl_req[c] = 1'b0;
    endtask

    task automatic pulse(input logic [NI-1:0] m);
        @(negedge clk); irq_in = irq_in | m;
        @(negedge clk); irq_in = irq_in & ~m;
    endtask

    task automatic drive(input int n, input logic v);
        @(negedge clk); irq_in[n] = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic b;
        logic [9:0] i0, i1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;

        // R1 reset state
        chk("R1 irq_out", irq_out, 0);
        chk("R1 ack_id cpu0", ack_id[9:0], 1023);
        chk("R1 ack_id cpu1", ack_id[19:10], 1023);
        rd(12'h100, 0, d, b); chk("R1 en 0..7", d, 8'hFF);
        rd(12'h101, 0, d, b); chk("R1 en 8..15", d, 8'hFF);
        rd(12'h102, 0, d, b); chk("R1 en 16..23", d, 8'h00);
        rd(12'hC00, 0, d, b); chk("R1 cfg 0..3", d, 8'hAA);
        rd(12'hC04, 0, d, b); chk("R1 cfg 16..19", d, 8'h00);
        rd(12'h805, 0, d, b); chk("R1 tgt 5", d, 8'h01);
        rd(12'h405, 1, d, b); chk("R1 prio 5 cpu1", d, 8'h00);

        // register vector table
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) begin
                @(negedge clk);
                reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = VEC[k].addr;
                reg_wdata = VEC[k].wd; reg_cpu = VEC[k].cpu;
                #1 chk($sformatf("vec %0d bad on write", k), reg_bad, VEC[k].bad);
                @(negedge clk);
                reg_sel = 1'b0; reg_wr = 1'b0;
            end
            rd(VEC[k].addr, VEC[k].cpu, d, b);
            chk($sformatf("vec %0d rdata", k), d, VEC[k].exp);
            chk($sformatf("vec %0d bad", k), b, VEC[k].bad);
        end

        // R2 edge line latches while disabled
        wr(12'h180, 8'h04, 0);
        drive(2, 1'b1); #1;
        chk("R2 disabled pending hidden", irq_out, 0);
        ack(0, i0); chk("R2 disabled not acked", i0, 1023);
        wr(12'h100, 8'h04, 0); #1;
        chk("R2 pending shows after enable", irq_out, 2'b01);
        drive(2, 1'b0);
        ack(0, i0); chk("R4 ack edge line", i0, 2);
        #1 chk("R4 pending cleared", irq_out, 0);
        cmpl(0, 2);
        ack(0, i0); chk("R5 edge no re-pend", i0, 1023);

        // R3 / R5 level line 40
        drive(40, 1'b1); #1;
        chk("R3 level disabled no pend", irq_out, 0);
        wr(12'h105, 8'h01, 0); #1;
        chk("R3 enable while high pends", irq_out, 2'b01);
        ack(0, i0); chk("R4 ack level line", i0, 40);
        #1 chk("R4 level not re-pended by ack", irq_out, 0);
        cmpl(0, 40); #1;
        chk("R5 level re-pend on complete", irq_out, 2'b01);
        ack(0, i0); chk("R5 re-pended ack", i0, 40);
        drive(40, 1'b0);
        cmpl(0, 40); #1;
        chk("R5 low level no re-pend", irq_out, 0);
        drive(40, 1'b1); #1;
        chk("R3 enabled level rise pends", irq_out, 2'b01);
        ack(0, i0);
        drive(40, 1'b0);
        cmpl(0, 40);

        // R4 priority order
        wr(12'h403, 8'h20, 0);
        wr(12'h404, 8'h20, 0);
        pulse((64'd1 << 3) | (64'd1 << 4) | (64'd1 << 5));
        ack(0, i0); chk("R4 tie lowest number", i0, 3);
        ack(0, i0); chk("R4 second", i0, 4);
        ack(0, i0); chk("R4 worst priority last", i0, 5);
        ack(0, i0); chk("R4 empty", i0, 1023);
        cmpl(0, 3); cmpl(0, 4); cmpl(0, 5);
        wr(12'h405, 8'h10, 0);
        pulse((64'd1 << 3) | (64'd1 << 5));
        ack(0, i0); chk("R4 lower value wins over number", i0, 5);
        ack(0, i0); chk("R4 then remaining", i0, 3);
        cmpl(0, 5); cmpl(0, 3);

        // R12 both CPUs acknowledge in one cycle
        wr(12'h806, 8'h03, 0);
        wr(12'h807, 8'h03, 0);
        pulse((64'd1 << 6) | (64'd1 << 7)); #1;
        chk("R6 both cpus requested", irq_out, 2'b11);
        ack2(i0, i1);
        chk("R12 cpu0 first", i0, 6);
        chk("R12 cpu1 next", i1, 7);
        #1 chk("R6 all taken", irq_out, 0);
        cmpl(0, 6); cmpl(1, 7);
        pulse(64'd1 << 6);
        ack2(i0, i1);
        chk("R12 single cpu0", i0, 6);
        chk("R12 single cpu1 none", i1, 1023);
        cmpl(0, 6);

        // R10 routing
        pulse(64'd1 << 8); #1;
        chk("R10 routed to cpu0 only", irq_out, 2'b01);
        ack(1, i1); chk("R10 cpu1 sees none", i1, 1023);
        ack(0, i0); chk("R10 cpu0 gets it", i0, 8);
        cmpl(0, 8);

        // R5 completion from a non-routed CPU
        wr(12'h829, 8'h02, 0);
        wr(12'h105, 8'h02, 0);
        drive(41, 1'b1); #1;
        chk("R6 routed to cpu1", irq_out, 2'b10);
        ack(1, i1); chk("R5 cpu1 ack 41", i1, 41);
        cmpl(0, 41); #1;
        chk("R5 other cpu completion no re-pend", irq_out, 0);
        cmpl(1, 41); #1;
        chk("R5 inactive completion ignored", irq_out, 0);
        drive(41, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule